// File: doc/BRIEF.md
# Paced Serial Byte Queue

This block sits between a packet producer and a byte-wide serial sink. The producer hands over whole response packets: a start strobe with a packet kind and a payload length, followed by one payload byte per strobe. The block writes a leading kind code ahead of the payload. It pads the stored packet to an even byte count, and keeps the bytes in a circular buffer. A drain side offers the oldest byte on a ready/valid port. After each accepted byte it waits a programmed number of clock cycles before it offers the next one, so the sink never sees bytes faster than the configured line speed.

Output is gated by a pair of control lines. Line 0 acts as a reset line and line 1 as a wake line. The drain starts only when both lines become high together. A falling edge on line 0 returns the block to its power-up condition. The block also keeps a two-bit modem status word, RTS and CTS, that follows handshake rules tied to line-parameter and modem-word writes. A packet that does not fit in the free space is dropped whole and raises a sticky overflow flag, and the block keeps running.

Top module: `pace_txq`

## Requirements
- R1: After `rstN` is released, `outValid` is 0, `ovfFlag` is 0, `wrIdle` is 1 and `mdmState` reads 2'b10 (bit 1 = CTS set, bit 0 = RTS clear).
- R2: No byte is offered until `ctlPins` reads 2'b11 in a cycle whose previous cycle did not read 2'b11. From then on the drain stays enabled until the next falling edge of `ctlPins[0]`.
- R3: A falling edge on `ctlPins[0]` empties the queue, disables the drain, clears `ovfFlag`, sets `mdmState` to 2'b10 and restores the default interval. Every one of these takes effect from the next cycle.
- R4: Two accepted bytes (cycles with `outValid` and `outReady` both high) are never closer than max(interval, 1) cycles apart. When bytes are waiting and the sink stays ready, the spacing is exactly that value.
- R5: Each accepted byte removes exactly one byte, in the order the bytes were written. `outValid` is high only while the drain is enabled, the queue is non-empty and the pacing wait has run out, and once high it stays high until the byte is accepted or a line-0 falling edge occurs.
- R6: A packet accepted on `pktStart` is stored as one kind byte, 8'h04 when `pktKind`=0 (event) or 8'h02 when `pktKind`=1 (ACL data), followed by its `pktLen` payload bytes in arrival order.
- R7: The stored length is `pktLen`+1 rounded up to an even count. When `pktLen` is even, one 8'h00 byte follows the payload.
- R8: When the rounded length exceeds the free space at `pktStart`, the whole packet is discarded, its `pktLen` data strobes are consumed and `ovfFlag` goes high and stays high until a line-0 falling edge. A packet that exactly fills the free space is stored.
- R9: A line-parameter write (`cfgWe`) loads `cfgInterval` as the new interval in clock cycles and sets CTS.
- R10: A modem-word write (`mdmWe`) loads RTS from `mdmWord[0]` and CTS from `mdmWord[1]`. If RTS was 1 and the written RTS is 0, CTS is cleared regardless of `mdmWord[1]`.
- R11: The interval after either reset is `CLK_HZ` cycles, which is one second at the parameterised clock rate.
- R12: `pktStart` is ignored while `wrIdle` is 0. `wrIdle` returns to 1 after the last payload or pad byte has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlPins | input | 2 | Control lines: bit 0 reset line, bit 1 wake line |
| cfgWe | input | 1 | Line-parameter write strobe |
| cfgInterval | input | IVW | Cycles between offered bytes |
| mdmWe | input | 1 | Modem-word write strobe |
| mdmWord | input | 2 | Written modem word: bit 1 CTS, bit 0 RTS |
| mdmState | output | 2 | Current modem status: bit 1 CTS, bit 0 RTS |
| pktStart | input | 1 | Begin a packet |
| pktKind | input | 1 | 0 event, 1 ACL data |
| pktLen | input | LENW | Payload length in bytes |
| dataValid | input | 1 | Payload byte strobe |
| dataByte | input | 8 | Payload byte |
| wrIdle | output | 1 | Ready for a new `pktStart` |
| outValid | output | 1 | Byte offered to the sink |
| outByte | output | 8 | Offered byte |
| outReady | input | 1 | Sink accepts the offered byte |
| ovfFlag | output | 1 | Sticky packet-drop flag |

## Verification
The bench builds the block with `CLK_HZ`=20, `DEPTH`=16, `IVW`=16 and `LENW`=6. A 20-cycle default interval makes the power-up and post-flush pacing measurable cycle by cycle instead of over a simulated second. A 16-byte queue lets two packets reach the overflow boundary: one packet is rejected and the next one exactly fills the queue. The small interval values 0, 3 and 5 exercise the minimum spacing and a sink that drops `outReady` part of the time.

// File: rtl/pace_txq_pkg.sv
package pace_txq_pkg;

  localparam logic [7:0] KIND_EVT_CODE = 8'h04;
  localparam logic [7:0] KIND_ACL_CODE = 8'h02;
  localparam logic [7:0] PAD_BYTE      = 8'h00;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_DATA,
    WS_PAD,
    WS_DROP
  } wrState_t;

  typedef struct packed {
    logic       wrEn;
    logic [7:0] wrData;
    logic       popEn;
    logic       flush;
  } qStrobe_t;

endpackage

// File: rtl/pace_txq_dp.sv
module pace_txq_dp
  import pace_txq_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  qStrobe_t        strobe,
  output logic [CNTW-1:0] occ,
  output logic [7:0]      headByte
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic          doWr;
  logic          doPop;

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign doWr  = strobe.wrEn & ~strobe.flush;
  assign doPop = strobe.popEn & ~strobe.flush;

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= strobe.wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (doWr)  wrPtr <= bump(wrPtr);
      if (doPop) rdPtr <= bump(rdPtr);
      case ({doWr, doPop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign headByte = mem[rdPtr];

endmodule

// File: rtl/pace_txq_ctrl.sv
module pace_txq_ctrl
  import pace_txq_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int DEPTH  = 4096,
  parameter int IVW    = 32,
  parameter int LENW   = 12,
  parameter int CNTW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      ctlPins,
  input  logic            cfgWe,
  input  logic [IVW-1:0]  cfgInterval,
  input  logic            mdmWe,
  input  logic [1:0]      mdmWord,
  output logic [1:0]      mdmState,
  input  logic            pktStart,
  input  logic            pktKind,
  input  logic [LENW-1:0] pktLen,
  input  logic            dataValid,
  input  logic [7:0]      dataByte,
  output logic            wrIdle,
  input  logic            outReady,
  input  logic [CNTW-1:0] occ,
  output logic            outValid,
  output logic            ovfFlag,
  output logic [IVW-1:0]  ivCur,
  output qStrobe_t        strobe
);

  localparam logic [IVW-1:0] IV_DEFAULT = IVW'(CLK_HZ);
  localparam int CW = ((LENW + 1 > CNTW) ? LENW + 1 : CNTW) + 1;

  // control lines
  logic [1:0] prevPins;
  logic       rstFall;
  logic       wakeRise;
  logic       linkEn;

  assign rstFall  = prevPins[0] & ~ctlPins[0];
  assign wakeRise = (&ctlPins) & ~(&prevPins);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPins <= 2'b00;
      linkEn   <= 1'b0;
    end else begin
      prevPins <= ctlPins;
      if (rstFall)       linkEn <= 1'b0;
      else if (wakeRise) linkEn <= 1'b1;
    end
  end

  // line parameters and modem status
  logic [IVW-1:0] ivReg;
  logic           ctsBit;
  logic           rtsBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivReg  <= IV_DEFAULT;
      ctsBit <= 1'b1;
      rtsBit <= 1'b0;
    end else if (rstFall) begin
      ivReg  <= IV_DEFAULT;
      ctsBit <= 1'b1;
      rtsBit <= 1'b0;
    end else begin
      if (mdmWe) begin
        rtsBit <= mdmWord[0];
        ctsBit <= (rtsBit & ~mdmWord[0]) ? 1'b0 : mdmWord[1];
      end
      if (cfgWe) begin
        ivReg  <= cfgInterval;
        ctsBit <= 1'b1;
      end
    end
  end

  assign mdmState = {ctsBit, rtsBit};
  assign ivCur    = ivReg;

  // packet write sequencing
  wrState_t        wrSt;
  logic [LENW-1:0] remLen;
  logic            padPend;
  logic            ovfReg;
  logic [CW-1:0]   needLen;
  logic [CW-1:0]   freeLen;
  logic            fits;
  logic            startNow;

  always_comb begin
    needLen = (CW'(pktLen) + CW'(2)) & ~CW'(1);
    freeLen = CW'(DEPTH) - CW'(occ);
    fits    = (needLen <= freeLen);
  end

  assign wrIdle   = (wrSt == WS_IDLE);
  assign startNow = wrIdle & pktStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSt    <= WS_IDLE;
      remLen  <= '0;
      padPend <= 1'b0;
      ovfReg  <= 1'b0;
    end else if (rstFall) begin
      wrSt    <= WS_IDLE;
      remLen  <= '0;
      padPend <= 1'b0;
      ovfReg  <= 1'b0;
    end else begin
      case (wrSt)
        WS_IDLE: begin
          if (startNow) begin
            remLen  <= pktLen;
            padPend <= ~pktLen[0];
            if (fits) begin
              wrSt <= (pktLen != '0) ? WS_DATA : WS_PAD;
            end else begin
              ovfReg <= 1'b1;
              wrSt   <= (pktLen != '0) ? WS_DROP : WS_IDLE;
            end
          end
        end
        WS_DATA: begin
          if (dataValid) begin
            remLen <= remLen - 1'b1;
            if (remLen == LENW'(1)) wrSt <= padPend ? WS_PAD : WS_IDLE;
          end
        end
        WS_PAD: wrSt <= WS_IDLE;
        WS_DROP: begin
          if (dataValid) begin
            remLen <= remLen - 1'b1;
            if (remLen == LENW'(1)) wrSt <= WS_IDLE;
          end
        end
        default: wrSt <= WS_IDLE;
      endcase
    end
  end

  assign ovfFlag = ovfReg;

  // pacing
  logic [IVW-1:0] paceCnt;
  logic           canSend;
  logic           accept;

  assign canSend  = linkEn & (occ != '0) & (paceCnt == '0);
  assign outValid = canSend;
  assign accept   = canSend & outReady & ~rstFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paceCnt <= '0;
    end else if (rstFall) begin
      paceCnt <= '0;
    end else if (accept) begin
      paceCnt <= (ivReg == '0) ? '0 : ivReg - 1'b1;
    end else if (paceCnt != '0) begin
      paceCnt <= paceCnt - 1'b1;
    end
  end

  // strobes to the datapath
  always_comb begin
    strobe        = '0;
    strobe.flush  = rstFall;
    strobe.popEn  = accept;
    case (wrSt)
      WS_IDLE: begin
        if (startNow && fits) begin
          strobe.wrEn   = 1'b1;
          strobe.wrData = pktKind ? KIND_ACL_CODE : KIND_EVT_CODE;
        end
      end
      WS_DATA: begin
        strobe.wrEn   = dataValid;
        strobe.wrData = dataByte;
      end
      WS_PAD: begin
        strobe.wrEn   = 1'b1;
        strobe.wrData = PAD_BYTE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pace_txq.sv
module pace_txq
  import pace_txq_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int DEPTH  = 4096,
  parameter int IVW    = 32,
  parameter int LENW   = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      ctlPins,
  input  logic            cfgWe,
  input  logic [IVW-1:0]  cfgInterval,
  input  logic            mdmWe,
  input  logic [1:0]      mdmWord,
  output logic [1:0]      mdmState,
  input  logic            pktStart,
  input  logic            pktKind,
  input  logic [LENW-1:0] pktLen,
  input  logic            dataValid,
  input  logic [7:0]      dataByte,
  output logic            wrIdle,
  output logic            outValid,
  output logic [7:0]      outByte,
  input  logic            outReady,
  output logic            ovfFlag
);

  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  qStrobe_t        strobe;
  logic [CNTW-1:0] occ;
  logic [IVW-1:0]  ivCur;

  pace_txq_ctrl #(
    .CLK_HZ(CLK_HZ), .DEPTH(DEPTH), .IVW(IVW), .LENW(LENW), .CNTW(CNTW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlPins(ctlPins),
    .cfgWe(cfgWe), .cfgInterval(cfgInterval),
    .mdmWe(mdmWe), .mdmWord(mdmWord), .mdmState(mdmState),
    .pktStart(pktStart), .pktKind(pktKind), .pktLen(pktLen),
    .dataValid(dataValid), .dataByte(dataByte), .wrIdle(wrIdle),
    .outReady(outReady), .occ(occ), .outValid(outValid),
    .ovfFlag(ovfFlag), .ivCur(ivCur), .strobe(strobe)
  );

  pace_txq_dp #(
    .DEPTH(DEPTH), .AW(AW), .CNTW(CNTW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .occ(occ), .headByte(outByte)
  );

endmodule

// File: rtl/pace_txq_chk.sv
module pace_txq_chk #(
  parameter int IVW = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic [1:0]     ctlPins,
  input logic           cfgWe,
  input logic           mdmWe,
  input logic [1:0]     mdmWord,
  input logic [1:0]     mdmState,
  input logic           outValid,
  input logic           outReady,
  input logic           ovfFlag,
  input logic [IVW-1:0] ivCur
);

  logic           prevRst;
  logic           fallNow;
  logic           takeNow;
  logic           havePrev;
  logic [IVW-1:0] gapCnt;
  logic [IVW-1:0] lastIv;

  assign fallNow = prevRst & ~ctlPins[0];
  assign takeNow = outValid & outReady & ~fallNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRst  <= 1'b0;
      havePrev <= 1'b0;
      gapCnt   <= '0;
      lastIv   <= '0;
    end else begin
      prevRst <= ctlPins[0];
      if (fallNow) begin
        havePrev <= 1'b0;
      end else if (takeNow) begin
        havePrev <= 1'b1;
        gapCnt   <= IVW'(1);
        lastIv   <= (ivCur == '0) ? IVW'(1) : ivCur;
      end else if (gapCnt != '1) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  AST_PACE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (takeNow && havePrev) |-> (gapCnt >= lastIv)); // R4

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    fallNow |=> !outValid); // R3

  AST_FLUSH_MODEM: assert property (@(posedge clk) disable iff (!rstN)
    fallNow |=> (mdmState == 2'b10)); // R3

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !fallNow) |=> outValid); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !fallNow) |=> ovfFlag); // R8

  AST_CFG_CTS: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> mdmState[1]); // R9

  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (mdmWe && mdmState[0] && !mdmWord[0] && !cfgWe && !fallNow) |=> !mdmState[1]); // R10

endmodule

bind pace_txq pace_txq_chk #(.IVW(IVW)) u_chk (
  .clk(clk), .rstN(rstN), .ctlPins(ctlPins), .cfgWe(cfgWe),
  .mdmWe(mdmWe), .mdmWord(mdmWord), .mdmState(mdmState),
  .outValid(outValid), .outReady(outReady), .ovfFlag(ovfFlag),
  .ivCur(ivCur)
);

// File: tb/tb_pace_txq.sv
`timescale 1ns/1ps
module tb_pace_txq;

  localparam int CLK_HZ = 20;
  localparam int DEPTH  = 16;
  localparam int IVW    = 16;
  localparam int LENW   = 6;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      ctlPins = 2'b00;
  logic            cfgWe = 1'b0;
  logic [IVW-1:0]  cfgInterval = '0;
  logic            mdmWe = 1'b0;
  logic [1:0]      mdmWord = 2'b00;
  logic [1:0]      mdmState;
  logic            pktStart = 1'b0;
  logic            pktKind = 1'b0;
  logic [LENW-1:0] pktLen = '0;
  logic            dataValid = 1'b0;
  logic [7:0]      dataByte = 8'h00;
  logic            wrIdle;
  logic            outValid;
  logic [7:0]      outByte;
  logic            outReady = 1'b0;
  logic            ovfFlag;

  pace_txq #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH), .IVW(IVW), .LENW(LENW)) dut (
    .clk(clk), .rstN(rstN), .ctlPins(ctlPins), .cfgWe(cfgWe),
    .cfgInterval(cfgInterval), .mdmWe(mdmWe), .mdmWord(mdmWord),
    .mdmState(mdmState), .pktStart(pktStart), .pktKind(pktKind),
    .pktLen(pktLen), .dataValid(dataValid), .dataByte(dataByte),
    .wrIdle(wrIdle), .outValid(outValid), .outByte(outByte),
    .outReady(outReady), .ovfFlag(ovfFlag)
  );

  always #4 clk = ~clk;

  int   nCmp = 0;
  int   nBad = 0;
  int   cycleCnt = 0;
  int   lastAcc = 0;
  bit   havePrev = 0;
  bit   exactGap = 0;
  bit   expEnabled = 0;
  int   expGap = CLK_HZ;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // monitor: pops the scoreboard on each accepted byte
  always @(negedge clk) begin
    #2;
    if (rstN && outValid && outReady) begin
      check(expEnabled, "R2 byte accepted while drain disabled", 1, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected byte", int'(outByte), -1);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(outByte == e, t, int'(outByte), int'(e));
      end
      if (havePrev) begin
        if (exactGap) check((cycleCnt - lastAcc) == expGap, "R4 exact spacing", cycleCnt - lastAcc, expGap);
        else          check((cycleCnt - lastAcc) >= expGap, "R4 minimum spacing", cycleCnt - lastAcc, expGap);
      end
      lastAcc  = cycleCnt;
      havePrev = 1;
    end
  end

  task automatic push(input logic [7:0] b, input string t);
    expQ.push_back(b);
    tagQ.push_back(t);
  endtask

  task automatic sendPkt(input bit kind, input int len, input logic [7:0] seed, input bit fits);
    @(negedge clk);
    pktStart = 1'b1; pktKind = kind; pktLen = LENW'(len);
    if (fits) push(kind ? 8'h02 : 8'h04, "R6 kind byte");
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pktStart = 1'b0; dataValid = 1'b1; dataByte = seed + 8'(i);
      if (fits) push(seed + 8'(i), "R6 payload byte");
    end
    @(negedge clk);
    pktStart = 1'b0; dataValid = 1'b0;
    if (fits && (len % 2 == 0)) push(8'h00, "R7 pad byte");
    @(negedge clk);
  endtask

  task automatic doCfg(input int iv);
    @(negedge clk); cfgWe = 1'b1; cfgInterval = IVW'(iv);
    @(negedge clk); cfgWe = 1'b0;
    expGap = (iv == 0) ? 1 : iv;
    #1;
  endtask

  task automatic doMdm(input logic [1:0] w);
    @(negedge clk); mdmWe = 1'b1; mdmWord = w;
    @(negedge clk); mdmWe = 1'b0;
    #1;
  endtask

  task automatic drain(input bit exact);
    havePrev = 0;
    exactGap = exact;
    @(negedge clk); outReady = 1'b1;
    for (int i = 0; i < 3000 && expQ.size() != 0; i++) @(negedge clk);
    check(expQ.size() == 0, "R5 queue drained", expQ.size(), 0);
    repeat (3) @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(ovfFlag == 1'b0, "R1 ovfFlag after reset", ovfFlag, 0);
    check(wrIdle == 1'b1, "R1 wrIdle after reset", wrIdle, 1);
    check(mdmState == 2'b10, "R1 modem state after reset", mdmState, 2'b10);

    // R2: only one line high -> no output
    ctlPins = 2'b01;
    sendPkt(1'b0, 3, 8'hA0, 1'b1);
    outReady = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    check(outValid == 1'b0, "R2 no output with one line high", outValid, 0);
    outReady = 1'b0;
    @(negedge clk);
    ctlPins = 2'b11; expEnabled = 1;
    // R11: default interval after hard reset is CLK_HZ cycles
    expGap = CLK_HZ;
    drain(1'b1);

    // R9 line parameters: interval 5, CTS stays set
    doCfg(5);
    check(mdmState[1] == 1'b1, "R9 CTS after line-parameter write", mdmState, 2'b10);
    sendPkt(1'b1, 4, 8'h10, 1'b1);
    drain(1'b1);

    // R4: interval 0 gives back-to-back bytes
    doCfg(0);
    sendPkt(1'b1, 3, 8'h30, 1'b1);
    drain(1'b1);

    // R5: sink toggling ready, interval 3
    doCfg(3);
    sendPkt(1'b0, 4, 8'h50, 1'b1);
    havePrev = 0; exactGap = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      outReady = (i % 3) != 0;
    end
    outReady = 1'b0;
    check(expQ.size() == 0, "R5 drained with stalling sink", expQ.size(), 0);

    // R12: second start while busy is ignored
    @(negedge clk);
    pktStart = 1'b1; pktKind = 1'b1; pktLen = LENW'(2);
    push(8'h02, "R6 kind byte");
    @(negedge clk);
    check(wrIdle == 1'b0, "R12 wrIdle low during packet", wrIdle, 0);
    pktStart = 1'b1; pktKind = 1'b0; pktLen = LENW'(5);
    dataValid = 1'b1; dataByte = 8'h71; push(8'h71, "R12 payload after ignored start");
    @(negedge clk);
    pktStart = 1'b0; dataByte = 8'h72; push(8'h72, "R12 payload after ignored start");
    @(negedge clk);
    dataValid = 1'b0; push(8'h00, "R7 pad byte");
    @(negedge clk); #1;
    check(wrIdle == 1'b1, "R12 wrIdle back after pad", wrIdle, 1);
    drain(1'b1);
    @(negedge clk); #1;
    check(outValid == 1'b0, "R12 nothing extra queued", outValid, 0);

    // R10 modem word rules
    doMdm(2'b01);
    check(mdmState == 2'b01, "R10 modem word stored", mdmState, 2'b01);
    doMdm(2'b11);
    check(mdmState == 2'b11, "R10 modem word stored", mdmState, 2'b11);
    doMdm(2'b10);
    check(mdmState == 2'b00, "R10 RTS fall clears CTS", mdmState, 2'b00);
    doCfg(3);
    check(mdmState == 2'b10, "R9 line write sets CTS", mdmState, 2'b10);

    // R8 overflow: 10 stored, 8 rejected, 6 exactly fills
    sendPkt(1'b0, 9, 8'h80, 1'b1);
    check(ovfFlag == 1'b0, "R8 no overflow yet", ovfFlag, 0);
    sendPkt(1'b1, 7, 8'h90, 1'b0);
    check(ovfFlag == 1'b1, "R8 overflow flagged", ovfFlag, 1);
    sendPkt(1'b1, 5, 8'hC0, 1'b1);
    drain(1'b1);
    check(ovfFlag == 1'b1, "R8 overflow sticky", ovfFlag, 1);

    // R3 soft reset
    doMdm(2'b01);
    doCfg(7);
    doMdm(2'b01);
    sendPkt(1'b0, 1, 8'hE0, 1'b1);
    @(negedge clk);
    ctlPins = 2'b10; expEnabled = 0;
    expQ.delete(); tagQ.delete();
    @(negedge clk); #1;
    check(outValid == 1'b0, "R3 output disabled", outValid, 0);
    check(ovfFlag == 1'b0, "R3 overflow cleared", ovfFlag, 0);
    check(mdmState == 2'b10, "R3 modem state restored", mdmState, 2'b10);
    @(negedge clk);
    ctlPins = 2'b11; expEnabled = 1;
    outReady = 1'b1;
    repeat (30) @(negedge clk);
    #1;
    check(outValid == 1'b0, "R3 queue flushed", outValid, 0);
    outReady = 1'b0;
    // R11: default interval restored after soft reset
    expGap = CLK_HZ;
    sendPkt(1'b0, 1, 8'hF1, 1'b1);
    drain(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule